// File: doc/BRIEF.md
# Rotate, Shift and Bit-Test Unit

This combinational datapath serves the bit-operation instruction group of an 8-bit processor. It receives the second byte of a prefixed opcode, the operand byte and the current flag byte. It returns the result byte, a write-back enable and the updated flag byte. The opcode byte has three fields. Bits [7:6] select the operation class. Bits [5:3] select either the shift/rotate kind or a bit index. Bits [2:0] name the destination register.

The register field only steers the write-back, and that steering is done elsewhere in the core, so this unit ignores it. There are four operation classes:
- eight rotate/shift kinds, one of which is the undocumented shift left that inserts a 1;
- a single-bit test, whose sign and undocumented bit-5/bit-3 flags depend on which bit was tested;
- setting one bit;
- clearing one bit.

Top module: `rsb_unit`

## Requirements
- R1: With opcode[7:6]=00, opcode[5:3] selects the operation: 0 rotate-left-circular, 1 rotate-right-circular, 2 rotate-left-through-carry, 3 rotate-right-through-carry, 4 arithmetic-shift-left, 5 arithmetic-shift-right, 6 shift-left-insert-one, 7 logical-shift-right. The write-back enable is 1.
- R2: Circular rotates copy the bit leaving the byte into the vacated end. Through-carry rotates fill the vacated end from incoming carry (flags_in[0]).
- R3: Arithmetic shift right keeps bit 7. Logical shift right puts 0 into bit 7. Arithmetic shift left puts 0 into bit 0. Shift-left-insert-one puts 1 into bit 0.
- R4: The flag byte layout is S=7, Z=6, F5=5, H=4, F3=3, P/V=2, N=1, C=0. After a rotate or shift, S, F5 and F3 are result bits 7, 5 and 3. Z is 1 when the result is zero. H=0 and N=0. P/V is 1 when the result holds an even number of ones. C is the bit shifted out.
- R5: With opcode[7:6]=01 (bit test of bit opcode[5:3]), Z is the inverse of the tested bit. H=1, N=0, P/V equals Z, and C keeps flags_in[0].
- R6: After a bit test, S is 1 only when bit 7 is tested and is 1. F5 is 1 only when bit 5 is tested and is 1. F3 is 1 only when bit 3 is tested and is 1.
- R7: A bit test drives the write-back enable to 0 and passes the operand unchanged on the result.
- R8: opcode[7:6]=11 sets, and 10 clears, bit opcode[5:3] of the operand. The other bits are untouched, the write-back enable is 1, and flags_out equals flags_in.
- R9: opcode[2:0] has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 8 | Second opcode byte: class, kind/index, register field |
| operand | input | 8 | Source byte |
| flags_in | input | 8 | Current flag byte |
| result | output | 8 | Resulting byte |
| wr_en | output | 1 | Result must be written back |
| flags_out | output | 8 | New flag byte |

## Verification
The through-carry rotates read the incoming carry and replace it in the same evaluation. A correct result needs the old C on the inserted bit and the outgoing bit on the new C. The bench provokes this by sweeping both values of flags_in[0] with operands whose end bits differ, and compares against its model on every clock. The bit test likewise produces C passthrough and a position-dependent S/F5/F3 together. It is judged on operands where the tested bit and bit 7 disagree.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned IDX_W  = $clog2(BYTE_W);

  typedef enum logic [1:0] {
    CLS_SHIFT = 2'b00,
    CLS_TEST  = 2'b01,
    CLS_CLEAR = 2'b10,
    CLS_SET   = 2'b11
  } op_class_e;

  typedef enum logic [2:0] {
    SH_ROTL_CIRC = 3'd0,
    SH_ROTR_CIRC = 3'd1,
    SH_ROTL_CARR = 3'd2,
    SH_ROTR_CARR = 3'd3,
    SH_SHL_ZERO  = 3'd4,
    SH_SHR_SIGN  = 3'd5,
    SH_SHL_ONE   = 3'd6,
    SH_SHR_ZERO  = 3'd7
  } shift_kind_e;

  typedef struct packed {
    logic s;
    logic z;
    logic f5;
    logic h;
    logic f3;
    logic pv;
    logic n;
    logic c;
  } flag_t;
endpackage

// File: rtl/rsb_shift_core.sv
module rsb_shift_core
  import rsb_pkg::*;
#(
  parameter int unsigned W = BYTE_W
) (
  input  shift_kind_e  kind,
  input  logic [W-1:0] din,
  input  logic         cin,
  output logic [W-1:0] dout,
  output logic         cout
);
  localparam int unsigned MSB = W - 1;

  always_comb begin
    dout = din;
    cout = 1'b0;
    unique case (kind)
      SH_ROTL_CIRC: begin dout = {din[MSB-1:0], din[MSB]}; cout = din[MSB]; end
      SH_ROTR_CIRC: begin dout = {din[0], din[MSB:1]};     cout = din[0];   end
      SH_ROTL_CARR: begin dout = {din[MSB-1:0], cin};      cout = din[MSB]; end
      SH_ROTR_CARR: begin dout = {cin, din[MSB:1]};        cout = din[0];   end
      SH_SHL_ZERO:  begin dout = {din[MSB-1:0], 1'b0};     cout = din[MSB]; end
      SH_SHR_SIGN:  begin dout = {din[MSB], din[MSB:1]};   cout = din[0];   end
      SH_SHL_ONE:   begin dout = {din[MSB-1:0], 1'b1};     cout = din[MSB]; end
      SH_SHR_ZERO:  begin dout = {1'b0, din[MSB:1]};       cout = din[0];   end
      default:      begin dout = din;                      cout = 1'b0;     end
    endcase
  end

  // the vacated end of the through-carry rotates must hold the old carry
  always_comb begin
    if (kind == SH_ROTL_CARR) p_rotl_carry_in_r2: assert (dout[0] == cin);
    if (kind == SH_ROTR_CARR) p_rotr_carry_in_r2: assert (dout[MSB] == cin);
    if (kind == SH_SHR_SIGN)  p_sign_kept_r3:     assert (dout[MSB] == din[MSB]);
  end
endmodule

// File: rtl/rsb_bit_core.sv
module rsb_bit_core
  import rsb_pkg::*;
#(
  parameter int unsigned W = BYTE_W
) (
  input  logic [IDX_W-1:0] idx,
  input  logic             set_not_clear,
  input  logic [W-1:0]     din,
  input  logic             cin,
  output logic [W-1:0]     dmod,
  output flag_t            tflags
);
  localparam int unsigned MSB = W - 1;

  logic [W-1:0] onehot;
  logic         picked;

  generate
    for (genvar g = 0; g < W; g++) begin : g_sel
      assign onehot[g] = (idx == IDX_W'(g));
    end
  endgenerate

  assign picked = |(din & onehot);
  assign dmod   = set_not_clear ? (din | onehot) : (din & ~onehot);

  always_comb begin
    tflags    = '0;
    tflags.z  = ~picked;
    tflags.pv = ~picked;
    tflags.h  = 1'b1;
    tflags.n  = 1'b0;
    tflags.c  = cin;
    tflags.s  = onehot[MSB] & din[MSB];
    tflags.f5 = onehot[5]   & din[5];
    tflags.f3 = onehot[3]   & din[3];
  end

  always_comb begin
    p_zero_vs_bit_r5: assert (tflags.z == ~din[idx]);
    p_sign_only_b7_r6: assert (!tflags.s || (idx == IDX_W'(MSB)));
  end
endmodule

// File: rtl/rsb_unit.sv
module rsb_unit
  import rsb_pkg::*;
#(
  parameter int unsigned W = BYTE_W
) (
  input  logic [7:0]   opcode,
  input  logic [W-1:0] operand,
  input  logic [7:0]   flags_in,
  output logic [W-1:0] result,
  output logic         wr_en,
  output logic [7:0]   flags_out
);
  localparam int unsigned MSB = W - 1;

  op_class_e        cls;
  logic [2:0]       sub;
  flag_t            fin;
  logic [W-1:0]     sh_res;
  logic             sh_c;
  logic [W-1:0]     bit_res;
  flag_t            bit_fl;
  flag_t            sh_fl;
  flag_t            fout;

  assign cls = op_class_e'(opcode[7:6]);
  assign sub = opcode[5:3];
  assign fin = flag_t'(flags_in);

  rsb_shift_core #(.W(W)) u_shift (
    .kind (shift_kind_e'(sub)),
    .din  (operand),
    .cin  (fin.c),
    .dout (sh_res),
    .cout (sh_c)
  );

  rsb_bit_core #(.W(W)) u_bit (
    .idx           (sub[IDX_W-1:0]),
    .set_not_clear (opcode[6]),
    .din           (operand),
    .cin           (fin.c),
    .dmod          (bit_res),
    .tflags        (bit_fl)
  );

  always_comb begin
    sh_fl    = '0;
    sh_fl.s  = sh_res[MSB];
    sh_fl.z  = (sh_res == '0);
    sh_fl.f5 = sh_res[5];
    sh_fl.f3 = sh_res[3];
    sh_fl.pv = ~^sh_res;
    sh_fl.c  = sh_c;
  end

  always_comb begin
    result = operand;
    wr_en  = 1'b1;
    fout   = fin;
    unique case (cls)
      CLS_SHIFT: begin result = sh_res;  fout = sh_fl;  end
      CLS_TEST:  begin result = operand; fout = bit_fl; wr_en = 1'b0; end
      CLS_CLEAR,
      CLS_SET:   begin result = bit_res; fout = fin;    end
      default:   begin result = operand; fout = fin;    end
    endcase
  end

  assign flags_out = fout;

  always_comb begin
    if (cls == CLS_TEST) p_test_no_write_r7: assert (!wr_en && result == operand);
    if (cls == CLS_SET || cls == CLS_CLEAR) p_flags_kept_r8: assert (flags_out == flags_in);
    if (cls == CLS_SHIFT) p_parity_even_r4: assert (flags_out[2] == ~^result);
    if (cls == CLS_SHIFT) p_halfcarry_clear_r4: assert (!flags_out[4] && !flags_out[1]);
  end
endmodule

// File: tb/rsb_unit_tb.sv
module rsb_unit_tb;
  logic       clk;
  logic [7:0] opcode, operand, flags_in;
  logic [7:0] result, flags_out;
  logic       wr_en;
  int checks, failures;
  bit done;

  rsb_unit u_dut (
    .opcode(opcode), .operand(operand), .flags_in(flags_in),
    .result(result), .wr_en(wr_en), .flags_out(flags_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int ones(input int v);
    int n = 0;
    for (int i = 0; i < 8; i++) if (((v >> i) % 2) == 1) n++;
    return n;
  endfunction

  // behavioural model: returns {wr, flags, result}
  function automatic logic [16:0] model(input int op, input int d, input int f);
    int cls = op / 64, sub = (op / 8) % 8;
    int cin = f % 2, r = d, c = 0, fl = f, wr = 1, bv;
    int b7 = d / 128, b0 = d % 2;
    if (cls == 0) begin
      case (sub)
        0: begin r = (d * 2) % 256 + b7; c = b7; end
        1: begin r = d / 2 + 128 * b0;   c = b0; end
        2: begin r = (d * 2) % 256 + cin; c = b7; end
        3: begin r = d / 2 + 128 * cin;  c = b0; end
        4: begin r = (d * 2) % 256;      c = b7; end
        5: begin r = d / 2 + 128 * b7;   c = b0; end
        6: begin r = (d * 2) % 256 + 1;  c = b7; end
        default: begin r = d / 2;        c = b0; end
      endcase
      fl = (r / 128) * 128 + (r == 0 ? 64 : 0) + ((r / 32) % 2) * 32 +
           ((r / 8) % 2) * 8 + ((ones(r) % 2 == 0) ? 4 : 0) + c;
    end else if (cls == 1) begin
      bv = (d >> sub) % 2;
      wr = 0;
      fl = ((sub == 7 && bv == 1) ? 128 : 0) + (bv == 0 ? 64 : 0) +
           ((sub == 5 && bv == 1) ? 32 : 0) + 16 +
           ((sub == 3 && bv == 1) ? 8 : 0) + (bv == 0 ? 4 : 0) + cin;
    end else begin
      bv = (d >> sub) % 2;
      if (cls == 3 && bv == 0) r = d + (1 << sub);
      if (cls == 2 && bv == 1) r = d - (1 << sub);
    end
    return {wr[0], fl[7:0], r[7:0]};
  endfunction

  task automatic apply(input int op, input int d, input int f, input string tag);
    logic [16:0] exp;
    @(posedge clk);
    opcode = op[7:0]; operand = d[7:0]; flags_in = f[7:0];
    @(negedge clk);
    exp = model(op, d, f);
    checks++;
    if ({wr_en, flags_out, result} !== exp) begin
      failures++;
      $display("FAIL %s op=%02h d=%02h f=%02h actual wr=%0b fl=%02h res=%02h expected wr=%0b fl=%02h res=%02h",
               tag, op, d, f, wr_en, flags_out, result, exp[16], exp[15:8], exp[7:0]);
    end
  endtask

  function automatic string tag_of(input int op);
    int cls = op / 64, sub = (op / 8) % 8;
    if (cls == 0) return (sub < 4) ? "R2/R4" : "R3/R4";
    if (cls == 1) return "R5/R6/R7";
    return "R8";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] r_a, f_a, r_b, f_b;
    logic       w_a, w_b;
    checks = 0; failures = 0; done = 0;
    opcode = 8'h00; operand = 8'h00; flags_in = 8'h00;
    // initial state: zero operand, class 0 kind 0 -> zero result, Z and P/V set (R4)
    apply(8'h00, 8'h00, 8'h00, "R4 initial");
    // each kind encoding on a distinctive operand (R1)
    for (int k = 0; k < 8; k++) apply(k * 8, 8'hA5, 8'h01, "R1 kind select");
    for (int k = 0; k < 8; k++) apply(k * 8, 8'h5A, 8'h00, "R1 kind select");
    // carry in/out collision (R2)
    apply(8'h10, 8'h80, 8'h01, "R2 rotl through carry");
    apply(8'h18, 8'h01, 8'h00, "R2 rotr through carry");
    // fills (R3)
    apply(8'h28, 8'h81, 8'h00, "R3 sign keep");
    apply(8'h30, 8'h00, 8'h00, "R3 insert one");
    // bit test corners (R5, R6, R7)
    apply(8'h78, 8'h80, 8'h01, "R6 bit7 set");
    apply(8'h68, 8'h20, 8'h00, "R6 bit5 set");
    apply(8'h58, 8'h08, 8'h01, "R6 bit3 set");
    apply(8'h40, 8'hA8, 8'h00, "R6 bit0 clear others set");
    apply(8'h50, 8'hFF, 8'hFF, "R5 bit2 set carry kept");
    apply(8'h48, 8'h00, 8'h00, "R7 no write");
    // set/clear (R8)
    apply(8'hF8, 8'h00, 8'h3C, "R8 set bit7");
    apply(8'h80, 8'hFF, 8'hC3, "R8 clear bit0");
    // sweep: every opcode, several operands, both carries
    for (int op = 0; op < 256; op++)
      for (int di = 0; di < 24; di++)
        for (int c = 0; c < 2; c++)
          apply(op, (di * 37 + op) % 256, (di * 91) % 256 - ((di * 91) % 2) + c, tag_of(op));
    // register field has no effect (R9)
    for (int op = 0; op < 256; op += 8) begin
      apply(op, 8'h96, 8'h01, "R9 base");
      r_a = result; f_a = flags_out; w_a = wr_en;
      apply(op + 5, 8'h96, 8'h01, "R9 alt field");
      r_b = result; f_b = flags_out; w_b = wr_en;
      checks++;
      if ({w_a, f_a, r_a} !== {w_b, f_b, r_b}) begin
        failures++;
        $display("FAIL R9 op=%02h actual %0b/%02h/%02h expected %0b/%02h/%02h",
                 op + 5, w_b, f_b, r_b, w_a, f_a, r_a);
      end
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule